// File: doc/BRIEF.md
# Trigger Pin Capture and Counter-Clear Unit

This block sits beside a free-running 24-bit timer and watches one asynchronous trigger pin. It first brings the pin into the clock domain. A filter can then be switched in so that only levels that stay steady count. On each edge of the chosen polarity, the unit does one of two things, depending on a single mode bit. It either copies the current timer value into a read-only capture register, or it emits a one-cycle request that clears the timer.

Every qualifying edge also raises a sticky event flag, which software clears by writing a 1. An interrupt output follows that flag when its enable is set. The timer itself lives outside this block. The unit only reads the timer's value and drives the clear request back to it.

Top module: `ext_trig_unit`

## Requirements
- R1: The 2-bit `edgeSel` input selects which pin transition qualifies. 2'b00 selects high-to-low, 2'b01 selects low-to-high, 2'b10 selects both, and 2'b11 makes no transition qualify.
- R2: While `pinEn` is 0, pin transitions have no effect: `capVal` keeps its value, `cntRstPulse` stays low and `evtFlag` is not set.
- R3: With `resetMode` = 0, a qualifying edge loads `countVal` into `capVal`. `capVal` changes at no other time.
- R4: With `resetMode` = 1, a qualifying edge produces a one-cycle high on `cntRstPulse` and leaves `capVal` unchanged.
- R5: Each qualifying edge sets `evtFlag`. A cycle with `flagClr` high clears it. When a set and a clear fall in the same cycle, the set wins.
- R6: `evtIrq` is high exactly when `evtFlag` and `irqEn` are both high.
- R7: The pin passes through a two-flop synchroniser. With `debEn` = 0, a pin change that settles before clock edge 1 shows its effect on `capVal`, `cntRstPulse` and `evtFlag` right after clock edge 3.
- R8: With `debEn` = 1, a new pin level is accepted only after it has been seen on 3 consecutive synchronised samples. A pin pulse lasting 2 clocks produces no event. The effect of a pin change appears right after clock edge 6.
- R9: After reset, `capVal` is 0 and `cntRstPulse`, `evtFlag` and `evtIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigPin | input | 1 | Raw asynchronous trigger pin |
| countVal | input | 24 | Running timer value |
| edgeSel | input | 2 | Qualifying transition select |
| pinEn | input | 1 | Enables the pin function |
| resetMode | input | 1 | 0: capture on edge, 1: clear counter on edge |
| irqEn | input | 1 | Interrupt enable |
| debEn | input | 1 | Debounce filter enable |
| flagClr | input | 1 | Write-1 clear strobe for the event flag |
| capVal | output | 24 | Captured timer value |
| cntRstPulse | output | 1 | One-cycle counter-clear request |
| evtFlag | output | 1 | Sticky external-event flag |
| evtIrq | output | 1 | Gated interrupt |

## Verification
The case that is hardest to bring about from the ports is a clear strobe landing in exactly the cycle in which a set event is registered. That cycle lies several register stages behind the pin. The bench counts those stages, then raises `flagClr` for precisely that cycle after a pin change, so the set-wins rule is exercised. Near the debounce boundary, pulses of two and three clocks are driven so that one side is rejected and the other accepted. Around all of this, a full sweep covers every combination of edge select, polarity, enable, mode and filter.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_ANY  = 2'b10,
    EDGE_OFF  = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic capLoad;
    logic cntClear;
    logic flagSet;
  } trigStrobe_t;

endpackage

// File: rtl/ext_trig_filter.sv
module ext_trig_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic debEn,
  output logic levelOut
);
  localparam int DCW = $clog2(DEB_LEN + 1);
  localparam logic [DCW-1:0] DLAST = DCW'(DEB_LEN - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   debLvl;
  logic [DCW-1:0]         debCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= pinRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinRaw};
      end
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  // debounce: count consecutive samples that disagree with the held level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debLvl <= 1'b0;
      debCnt <= '0;
    end else if (syncLvl == debLvl) begin
      debCnt <= '0;
    end else if (debCnt == DLAST) begin
      debLvl <= syncLvl;
      debCnt <= '0;
    end else begin
      debCnt <= debCnt + 1'b1;
    end
  end

  assign levelOut = debEn ? debLvl : syncLvl;

endmodule

// File: rtl/ext_trig_ctrl.sv
module ext_trig_ctrl
  import ext_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        level,
  input  logic [1:0]  edgeSel,
  input  logic        pinEn,
  input  logic        resetMode,
  output trigStrobe_t strobe
);
  logic prevLvl;
  logic isRise;
  logic isFall;
  logic hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= level;
  end

  assign isRise = level & ~prevLvl;
  assign isFall = ~level & prevLvl;

  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      EDGE_FALL: hit = isFall;
      EDGE_RISE: hit = isRise;
      EDGE_ANY:  hit = isRise | isFall;
      default:   hit = 1'b0;
    endcase
    hit = hit & pinEn;
  end

  always_comb begin
    strobe.flagSet  = hit;
    strobe.capLoad  = hit & ~resetMode;
    strobe.cntClear = hit & resetMode;
  end

endmodule

// File: rtl/ext_trig_dp.sv
module ext_trig_dp
  import ext_trig_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countVal,
  input  trigStrobe_t      strobe,
  input  logic             flagClr,
  input  logic             irqEn,
  output logic [CNT_W-1:0] capVal,
  output logic             cntRstPulse,
  output logic             evtFlag,
  output logic             evtIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capVal <= '0;
    else if (strobe.capLoad) capVal <= countVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntRstPulse <= 1'b0;
    else       cntRstPulse <= strobe.cntClear;
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               evtFlag <= 1'b0;
    else if (strobe.flagSet) evtFlag <= 1'b1;
    else if (flagClr)        evtFlag <= 1'b0;
  end

  assign evtIrq = evtFlag & irqEn;

endmodule

// File: rtl/ext_trig_unit.sv
module ext_trig_unit
  import ext_trig_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigPin,
  input  logic [CNT_W-1:0] countVal,
  input  logic [1:0]       edgeSel,
  input  logic             pinEn,
  input  logic             resetMode,
  input  logic             irqEn,
  input  logic             debEn,
  input  logic             flagClr,
  output logic [CNT_W-1:0] capVal,
  output logic             cntRstPulse,
  output logic             evtFlag,
  output logic             evtIrq
);
  logic        pinLvl;
  trigStrobe_t strobe;

  ext_trig_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_filter (
    .clk(clk), .rstN(rstN), .pinRaw(trigPin), .debEn(debEn), .levelOut(pinLvl)
  );

  ext_trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .level(pinLvl), .edgeSel(edgeSel),
    .pinEn(pinEn), .resetMode(resetMode), .strobe(strobe)
  );

  ext_trig_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .countVal(countVal), .strobe(strobe),
    .flagClr(flagClr), .irqEn(irqEn), .capVal(capVal),
    .cntRstPulse(cntRstPulse), .evtFlag(evtFlag), .evtIrq(evtIrq)
  );

endmodule

// File: rtl/ext_trig_chk.sv
module ext_trig_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       edgeSel,
  input logic             pinEn,
  input logic             resetMode,
  input logic             irqEn,
  input logic [CNT_W-1:0] capVal,
  input logic             cntRstPulse,
  input logic             evtFlag,
  input logic             evtIrq
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinEn |=> (!cntRstPulse && $stable(capVal) && !$rose(evtFlag)));

  // R1
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel == 2'b11) |=> (!cntRstPulse && !$rose(evtFlag)));

  // R3
  cap_only_mode0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capVal) |-> ($past(!resetMode) && $past(pinEn) && evtFlag));

  // R4
  clear_no_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntRstPulse |-> ($stable(capVal) && $past(resetMode) && evtFlag));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtIrq |-> (evtFlag && irqEn));

endmodule

bind ext_trig_unit ext_trig_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .edgeSel(edgeSel), .pinEn(pinEn),
  .resetMode(resetMode), .irqEn(irqEn), .capVal(capVal),
  .cntRstPulse(cntRstPulse), .evtFlag(evtFlag), .evtIrq(evtIrq)
);

// File: tb/ext_trig_unit_bench.sv
`timescale 1ns/1ps
module ext_trig_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigPin = 1'b0;
  logic [23:0] countVal = '0;
  logic [1:0]  edgeSel = 2'b00;
  logic        pinEn = 1'b0;
  logic        resetMode = 1'b0;
  logic        irqEn = 1'b0;
  logic        debEn = 1'b0;
  logic        flagClr = 1'b0;
  logic [23:0] capVal;
  logic        cntRstPulse, evtFlag, evtIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [23:0] expCap = '0;

  always #2.5 clk = ~clk;

  ext_trig_unit u_ext_trig_unit (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .countVal(countVal),
    .edgeSel(edgeSel), .pinEn(pinEn), .resetMode(resetMode), .irqEn(irqEn),
    .debEn(debEn), .flagClr(flagClr), .capVal(capVal),
    .cntRstPulse(cntRstPulse), .evtFlag(evtFlag), .evtIrq(evtIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    flagClr = 1'b1;
    cycles(1);
    flagClr = 1'b0;
    check("R5 clear", {31'b0, evtFlag}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int idx;
    bit det;
    int lat;
    @(negedge clk);
    cycles(2);
    // R9 reset state
    check("R9 capVal", {8'b0, capVal}, 32'd0);
    check("R9 pulse", {31'b0, cntRstPulse}, 32'd0);
    check("R9 flag", {31'b0, evtFlag}, 32'd0);
    check("R9 irq", {31'b0, evtIrq}, 32'd0);
    rstN = 1'b1;
    cycles(2);

    idx = 0;
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++)
        for (int e = 0; e < 2; e++)
          for (int m = 0; m < 2; m++)
            for (int dir = 0; dir < 2; dir++) begin
              // park pin at the opposite level with the function disabled
              pinEn = 1'b0;
              debEn = d[0];
              trigPin = ~dir[0];
              cycles(10);
              edgeSel = s[1:0];
              resetMode = m[0];
              irqEn = idx[0] ^ idx[3];
              countVal = 24'hA00000 ^ (24'(idx) * 24'h01F3B7);
              clear_flag();
              pinEn = e[0];
              det = e[0] && ((s == 0 && dir == 0) || (s == 1 && dir == 1) || (s == 2));
              lat = d ? 6 : 3;
              trigPin = dir[0];
              cycles(lat - 1);
              // R7 / R8: nothing visible one edge early
              check(d ? "R8 early" : "R7 early", {31'b0, evtFlag}, 32'd0);
              cycles(1);
              if (det && !m[0]) expCap = countVal;
              // R1 / R2 qualification, R5 flag set
              check(e ? "R1 flag" : "R2 flag", {31'b0, evtFlag}, {31'b0, det});
              // R3 capture
              check("R3 capVal", {8'b0, capVal}, {8'b0, expCap});
              // R4 clear pulse
              check("R4 pulse", {31'b0, cntRstPulse}, {31'b0, det && m[0]});
              // R6 irq gating
              check("R6 irq", {31'b0, evtIrq}, {31'b0, det && irqEn});
              cycles(1);
              check("R4 one cycle", {31'b0, cntRstPulse}, 32'd0);
              check("R5 sticky", {31'b0, evtFlag}, {31'b0, det});
              idx++;
            end

    // R8 debounce boundary: 2-clock pulse rejected, 3-clock pulse accepted
    pinEn = 1'b0; debEn = 1'b1; trigPin = 1'b0; edgeSel = 2'b01; resetMode = 1'b1;
    cycles(10);
    clear_flag();
    pinEn = 1'b1;
    trigPin = 1'b1; cycles(2); trigPin = 1'b0;
    cycles(10);
    check("R8 short pulse", {31'b0, evtFlag}, 32'd0);
    trigPin = 1'b1; cycles(3); trigPin = 1'b0;
    cycles(10);
    check("R8 long pulse", {31'b0, evtFlag}, 32'd1);

    // R7 without filter a 2-clock pulse is seen
    debEn = 1'b0;
    cycles(10);
    clear_flag();
    trigPin = 1'b1; cycles(2); trigPin = 1'b0;
    cycles(6);
    check("R7 short pulse", {31'b0, evtFlag}, 32'd1);

    // R5 set wins over a same-cycle clear
    clear_flag();
    trigPin = 1'b1;
    cycles(2);
    flagClr = 1'b1;
    cycles(1);
    flagClr = 1'b0;
    check("R5 set priority", {31'b0, evtFlag}, 32'd1);
    clear_flag();
    trigPin = 1'b0;
    cycles(6);
    check("R5 fall ignored", {31'b0, evtFlag}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule